// File: doc/BRIEF.md
# Pixel to bus-cycle serializer

This block turns a stream of pixels of 12, 16, 18 or 24 bits into words for a parallel display bus that is 8, 9, 12 or 16 lines wide. Depending on the ratio between pixel size and bus width, a pixel goes out in one, two or three bus words, or two pixels are packed into three words. Every word asks a downstream strobe generator for one write access through a valid/acknowledge pair. The word also carries a register-select level: low marks a command, high marks a parameter or pixel data.

A frame starts with a start pulse that latches the pixel size, the bus width and the pixel count. The count is normally the width times the height of the region. The block takes exactly that many pixels, sends the last word and then clears its busy flag with a one-cycle frame-done pulse. Between frames, single command or parameter words can be written straight to the bus without passing through the pixel path.

Top module: `pix_bus_serializer`

## Requirements
- R1: The size selector (0=12, 1=16, 2=18, 3=24 bits) and the width selector (0=8, 1=9, 2=12, 3=16 lines) give the mode. If pixel bits equal the line count, the mode is one word per pixel. At 2 or 3 times the line count it is two or three words per pixel. If twice the pixel bits equal three times the line count, two pixels go out in three words. Any other pair is illegal: a start with it leaves `busy` low and sets `cfg_err`, and `cfg_err` stays set until a start with a legal pair.
- R2: A legal start with a non-zero count while idle raises `busy` in the next cycle. It latches the selectors and the count, so later changes on the configuration inputs do not affect the running frame.
- R3: In the one-, two- and three-words-per-pixel modes with L lines and B pixel bits, word k (k from 0) carries pixel bits [B-1-k·L : B-L-(k+1)·L+L], most significant slice first. For 16 bits on 8 lines this is bits 15:8 then 7:0. For 24 bits on 8 lines it is 23:16, 15:8, 7:0.
- R4: In the two-pixels-in-three-words mode with H = L/2, the first word is the top L bits of the first pixel. The second word holds the low H bits of the first pixel in its upper half and the top H bits of the second pixel in its lower half. The third word is the low L bits of the second pixel.
- R5: In that mode, when the frame has an odd pixel count, the final pixel goes out in two words: its top L bits, then its low H bits in the upper half with a zero lower half.
- R6: A frame accepts exactly the latched number of pixels. The clock edge that takes the last word also clears `busy`, and `frame_done` is high for exactly the one cycle that follows.
- R7: A start while `busy` is high has no effect on the running frame. A legal start with a count of zero leaves the block idle and gives no `frame_done`.
- R8: While idle, an accepted command request (`cmd_valid` and `cmd_ready`) puts out one word with `bus_a0` equal to `cmd_is_param`, so 0 marks a command and 1 a parameter. Pixel words always carry `bus_a0` = 1. `cmd_ready` is low while `busy` is high.
- R9: A word stays on `bus_word`/`bus_a0` with `bus_valid` high until the cycle in which `bus_ack` is high. A new word can be loaded in the same cycle as that acknowledge.
- R10: Pixel bits above the pixel size are ignored. Output bits at and above the line count are always zero, for pixel words and for command or parameter words.
- R11: After reset, `busy`, `bus_valid`, `pix_ready`, `cfg_err` and `frame_done` are low, and `cmd_ready` is high.
- R12: A command request and a legal start in the same idle cycle are both taken. The command word goes out before any pixel word of the new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bpp_sel | input | 2 | Pixel size selector |
| cfg_lines_sel | input | 2 | Bus width selector |
| cfg_pix_count | input | CNT_W | Pixels in the frame |
| start | input | 1 | Frame start request |
| cfg_err | output | 1 | Last start had an illegal size/width pair |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |
| pix_valid | input | 1 | Pixel available |
| pix_data | input | 24 | Pixel, right aligned |
| pix_ready | output | 1 | Pixel taken when high with pix_valid |
| cmd_valid | input | 1 | Single command/parameter write request |
| cmd_is_param | input | 1 | 1 for parameter, 0 for command |
| cmd_data | input | 16 | Command/parameter value |
| cmd_ready | output | 1 | Command request taken when high with cmd_valid |
| bus_valid | output | 1 | Word waiting for a write access |
| bus_word | output | 16 | Bus word, low lines used |
| bus_a0 | output | 1 | Register-select level for the word |
| bus_ack | input | 1 | Strobe generator takes the word |

## Verification
The single-write path and the frame start can fall in the same idle cycle, because both are decided from the idle state. The bench raises `cmd_valid` and `start` on the same edge and places the command word ahead of the frame's words in its reference queue. Every acknowledged word is then compared in order against that queue, so a lost command, a refused start or a pixel word slipping ahead shows up as a mismatch. The same frame also tries a second start while busy and scrambles the configuration inputs, and the bench expects the frame to end at the first count.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
package pbs_pkg;

    localparam int PIX_W  = 24;
    localparam int BUS_W  = 16;
    localparam int BITS_W = 6;

    typedef enum logic [1:0] {
        FMT_ONE   = 2'd0,
        FMT_TWO   = 2'd1,
        FMT_THREE = 2'd2,
        FMT_PAIR  = 2'd3
    } cyc_fmt_e;

    typedef struct packed {
        logic              busy;
        logic              gather;
        logic              drain;
        logic              have_one;
        logic              lone;
        logic [1:0]        phase;
        cyc_fmt_e          fmt;
        logic [BITS_W-1:0] bpp_bits;
        logic [BITS_W-1:0] line_bits;
        logic [PIX_W-1:0]  p0;
        logic [PIX_W-1:0]  p1;
        logic              out_valid;
        logic [BUS_W-1:0]  out_word;
        logic              out_a0;
        logic              done;
        logic              err;
    } ser_state_t;

    function automatic logic [BITS_W-1:0] size_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return BITS_W'(12);
            2'd1:    return BITS_W'(16);
            2'd2:    return BITS_W'(18);
            default: return BITS_W'(24);
        endcase
    endfunction

    function automatic logic [BITS_W-1:0] width_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return BITS_W'(8);
            2'd1:    return BITS_W'(9);
            2'd2:    return BITS_W'(12);
            default: return BITS_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/pbs_fmt_decode.sv
`timescale 1ns/1ps
module pbs_fmt_decode
    import pbs_pkg::*;
(
    input  logic [1:0]        bpp_sel,
    input  logic [1:0]        lines_sel,
    output logic              legal,
    output cyc_fmt_e          fmt,
    output logic [BITS_W-1:0] bpp_bits,
    output logic [BITS_W-1:0] line_bits
);

    logic [7:0] b8;
    logic [7:0] l8;

    always_comb begin
        bpp_bits  = size_bits(bpp_sel);
        line_bits = width_bits(lines_sel);
        b8 = 8'(bpp_bits);
        l8 = 8'(line_bits);
        legal = 1'b1;
        fmt   = FMT_ONE;
        if (b8 == l8) begin
            fmt = FMT_ONE;
        end else if (b8 == (l8 << 1)) begin
            fmt = FMT_TWO;
        end else if (b8 == (l8 + (l8 << 1))) begin
            fmt = FMT_THREE;
        end else if ((b8 << 1) == (l8 + (l8 << 1))) begin
            fmt = FMT_PAIR;
        end else begin
            legal = 1'b0;
        end
    end

endmodule

// File: rtl/pbs_slicer.sv
`timescale 1ns/1ps
module pbs_slicer
    import pbs_pkg::*;
(
    input  cyc_fmt_e          fmt,
    input  logic [BITS_W-1:0] bpp_bits,
    input  logic [BITS_W-1:0] line_bits,
    input  logic [1:0]        phase,
    input  logic              lone,
    input  logic [PIX_W-1:0]  p0,
    input  logic [PIX_W-1:0]  p1,
    output logic [BUS_W-1:0]  word
);

    logic [31:0]       a32;
    logic [31:0]       b32;
    logic [31:0]       full_mask;
    logic [31:0]       half_mask;
    logic [31:0]       res;
    logic [BITS_W-1:0] half;
    logic [BITS_W-1:0] shamt;

    always_comb begin
        a32       = 32'(p0);
        b32       = 32'(p1);
        half      = line_bits >> 1;
        full_mask = (32'd1 << line_bits) - 32'd1;
        half_mask = (32'd1 << half) - 32'd1;
        shamt     = bpp_bits - line_bits;
        if (fmt == FMT_PAIR) begin
            case (phase)
                2'd0:    res = (a32 >> shamt) & full_mask;
                2'd1:    res = ((a32 & half_mask) << half)
                             | (lone ? 32'd0 : ((b32 >> (bpp_bits - half)) & half_mask));
                default: res = b32 & full_mask;
            endcase
        end else begin
            case (phase)
                2'd0:    shamt = bpp_bits - line_bits;
                2'd1:    shamt = bpp_bits - (line_bits << 1);
                default: shamt = bpp_bits - (line_bits + (line_bits << 1));
            endcase
            res = (a32 >> shamt) & full_mask;
        end
        word = res[BUS_W-1:0];
    end

endmodule

// File: rtl/pbs_frame_ctr.sv
`timescale 1ns/1ps
module pbs_frame_ctr #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] remaining,
    output logic             is_last,
    output logic             is_zero
);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign remaining = cnt_q;
    assign is_last   = (cnt_q == CNT_W'(1));
    assign is_zero   = (cnt_q == '0);

    // R6: a pixel is never taken beyond the programmed count
    assert_ctr_no_underflow_R6: assert property (
        @(posedge clk) disable iff (!rst_n) dec |-> (cnt_q != '0)
    );

endmodule

// File: rtl/pix_bus_serializer.sv
`timescale 1ns/1ps
module pix_bus_serializer
    import pbs_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_bpp_sel,
    input  logic [1:0]       cfg_lines_sel,
    input  logic [CNT_W-1:0] cfg_pix_count,
    input  logic             start,
    output logic             cfg_err,
    output logic             busy,
    output logic             frame_done,
    input  logic             pix_valid,
    input  logic [23:0]      pix_data,
    output logic             pix_ready,
    input  logic             cmd_valid,
    input  logic             cmd_is_param,
    input  logic [15:0]      cmd_data,
    output logic             cmd_ready,
    output logic             bus_valid,
    output logic [15:0]      bus_word,
    output logic             bus_a0,
    input  logic             bus_ack
);

    ser_state_t        st_d;
    ser_state_t        st_q;

    logic              dec_legal;
    cyc_fmt_e          dec_fmt;
    logic [BITS_W-1:0] dec_bpp;
    logic [BITS_W-1:0] dec_lines;
    logic [BUS_W-1:0]  slice_word;
    logic [31:0]       cmd_mask32;
    logic [1:0]        last_phase;
    logic              out_free;
    logic              ctr_load;
    logic              ctr_dec;
    logic [CNT_W-1:0]  ctr_rem;
    logic              ctr_last;
    logic              ctr_zero;

    pbs_fmt_decode u_decode (
        .bpp_sel   (cfg_bpp_sel),
        .lines_sel (cfg_lines_sel),
        .legal     (dec_legal),
        .fmt       (dec_fmt),
        .bpp_bits  (dec_bpp),
        .line_bits (dec_lines)
    );

    pbs_slicer u_slicer (
        .fmt       (st_q.fmt),
        .bpp_bits  (st_q.bpp_bits),
        .line_bits (st_q.line_bits),
        .phase     (st_q.phase),
        .lone      (st_q.lone),
        .p0        (st_q.p0),
        .p1        (st_q.p1),
        .word      (slice_word)
    );

    pbs_frame_ctr #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctr_load),
        .load_val  (cfg_pix_count),
        .dec       (ctr_dec),
        .remaining (ctr_rem),
        .is_last   (ctr_last),
        .is_zero   (ctr_zero)
    );

    assign cmd_mask32 = (32'd1 << dec_lines) - 32'd1;

    always_comb begin
        case (st_q.fmt)
            FMT_ONE:   last_phase = 2'd0;
            FMT_TWO:   last_phase = 2'd1;
            FMT_THREE: last_phase = 2'd2;
            default:   last_phase = st_q.lone ? 2'd1 : 2'd2;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.done = 1'b0;
        ctr_load = 1'b0;
        ctr_dec  = 1'b0;
        out_free = !st_q.out_valid || bus_ack;

        if (st_q.out_valid && bus_ack) begin
            st_d.out_valid = 1'b0;
        end

        if (!st_q.busy) begin
            if (cmd_valid && out_free) begin
                st_d.out_valid = 1'b1;
                st_d.out_word  = cmd_data & cmd_mask32[BUS_W-1:0];
                st_d.out_a0    = cmd_is_param;
            end
            if (start) begin
                if (!dec_legal) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.err = 1'b0;
                    if (cfg_pix_count != '0) begin
                        ctr_load       = 1'b1;
                        st_d.busy      = 1'b1;
                        st_d.gather    = 1'b1;
                        st_d.drain     = 1'b0;
                        st_d.have_one  = 1'b0;
                        st_d.lone      = 1'b0;
                        st_d.phase     = 2'd0;
                        st_d.fmt       = dec_fmt;
                        st_d.bpp_bits  = dec_bpp;
                        st_d.line_bits = dec_lines;
                    end
                end
            end
        end else if (st_q.gather) begin
            if (pix_valid) begin
                ctr_dec = 1'b1;
                if (st_q.fmt != FMT_PAIR) begin
                    st_d.p0     = pix_data;
                    st_d.gather = 1'b0;
                    st_d.lone   = 1'b0;
                    st_d.phase  = 2'd0;
                end else if (!st_q.have_one) begin
                    st_d.p0 = pix_data;
                    if (ctr_last) begin
                        st_d.gather = 1'b0;
                        st_d.lone   = 1'b1;
                        st_d.phase  = 2'd0;
                    end else begin
                        st_d.have_one = 1'b1;
                    end
                end else begin
                    st_d.p1       = pix_data;
                    st_d.have_one = 1'b0;
                    st_d.gather   = 1'b0;
                    st_d.lone     = 1'b0;
                    st_d.phase    = 2'd0;
                end
            end
        end else if (!st_q.drain) begin
            if (out_free) begin
                st_d.out_valid = 1'b1;
                st_d.out_word  = slice_word;
                st_d.out_a0    = 1'b1;
                if (st_q.phase == last_phase) begin
                    if (ctr_zero) begin
                        st_d.drain = 1'b1;
                    end else begin
                        st_d.gather = 1'b1;
                    end
                end else begin
                    st_d.phase = st_q.phase + 2'd1;
                end
            end
        end else begin
            if (out_free) begin
                st_d.busy  = 1'b0;
                st_d.drain = 1'b0;
                st_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_err    = st_q.err;
    assign busy       = st_q.busy;
    assign frame_done = st_q.done;
    assign pix_ready  = st_q.busy && st_q.gather;
    assign cmd_ready  = !st_q.busy && out_free;
    assign bus_valid  = st_q.out_valid;
    assign bus_word   = st_q.out_word;
    assign bus_a0     = st_q.out_a0;

    // R9: an unacknowledged word is held unchanged
    assert_word_hold_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_word) && $stable(bus_a0))
    );

    // R6: the end-of-frame pulse lasts one cycle
    assert_done_single_R6: assert property (
        @(posedge clk) disable iff (!rst_n) frame_done |=> !frame_done
    );

    // R6: the pulse follows a busy frame and busy is already low
    assert_done_ends_busy_R6: assert property (
        @(posedge clk) disable iff (!rst_n) frame_done |-> (!busy && $past(busy))
    );

    // R1: an illegal pair never starts a frame and flags the error
    assert_refuse_illegal_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (start && !busy && !dec_legal) |=> (!busy && cfg_err)
    );

endmodule

// File: tb/pix_bus_serializer_tb.sv
`timescale 1ns/1ps
module pix_bus_serializer_tb;

    localparam int CNT_W = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cfg_bpp_sel = '0;
    logic [1:0]       cfg_lines_sel = '0;
    logic [CNT_W-1:0] cfg_pix_count = '0;
    logic             start = 1'b0;
    logic             cfg_err;
    logic             busy;
    logic             frame_done;
    logic             pix_valid = 1'b0;
    logic [23:0]      pix_data = '0;
    logic             pix_ready;
    logic             cmd_valid = 1'b0;
    logic             cmd_is_param = 1'b0;
    logic [15:0]      cmd_data = '0;
    logic             cmd_ready;
    logic             bus_valid;
    logic [15:0]      bus_word;
    logic             bus_a0;
    logic             bus_ack = 1'b0;

    pix_bus_serializer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_bpp_sel(cfg_bpp_sel), .cfg_lines_sel(cfg_lines_sel),
        .cfg_pix_count(cfg_pix_count), .start(start),
        .cfg_err(cfg_err), .busy(busy), .frame_done(frame_done),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .cmd_valid(cmd_valid), .cmd_is_param(cmd_is_param), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready),
        .bus_valid(bus_valid), .bus_word(bus_word), .bus_a0(bus_a0), .bus_ack(bus_ack)
    );

    always #5 clk = ~clk;

    int          n_chk = 0;
    int          n_fail = 0;
    int          pixq[$];
    int          expq[$];
    int          pidx = 0;
    bit          want_done = 0;
    bit          done_seen = 0;
    bit          frame_on = 0;
    bit          finished = 0;
    string       cur_req = "R3";

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic int size_of(input int s);
        case (s)
            0: return 12;
            1: return 16;
            2: return 18;
            default: return 24;
        endcase
    endfunction

    function automatic int width_of(input int s);
        case (s)
            0: return 8;
            1: return 9;
            2: return 12;
            default: return 16;
        endcase
    endfunction

    // 1..3 words per pixel, 4 for two pixels in three words, 0 illegal
    function automatic int mode_of(input int b, input int l);
        if (b == l) return 1;
        if (b == 2 * l) return 2;
        if (b == 3 * l) return 3;
        if (2 * b == 3 * l) return 4;
        return 0;
    endfunction

    task automatic build(input int b, input int l, input int np);
        int m, lm, h, hm, bm;
        m  = mode_of(b, l);
        lm = (1 << l) - 1;
        h  = l / 2;
        hm = (1 << h) - 1;
        bm = (1 << b) - 1;
        if (m == 4) begin
            for (int i = 0; i < np; i += 2) begin
                int p0, p1;
                p0 = pixq[i] & bm;
                expq.push_back(32'h10000 | ((p0 >> (b - l)) & lm));
                if (i + 1 < np) begin
                    p1 = pixq[i + 1] & bm;
                    expq.push_back(32'h10000 | ((p0 & hm) << h) | ((p1 >> (b - h)) & hm));
                    expq.push_back(32'h10000 | (p1 & lm));
                end else begin
                    expq.push_back(32'h10000 | ((p0 & hm) << h));
                end
            end
        end else begin
            for (int i = 0; i < np; i++) begin
                int p;
                p = pixq[i] & bm;
                for (int k = 0; k < m; k++) begin
                    expq.push_back(32'h10000 | ((p >> (b - (k + 1) * l)) & lm));
                end
            end
        end
    endtask

    // drive at a falling edge, then judge what the next rising edge transfers
    task automatic observe(input int mode);
        bit a, v;
        int exp;
        chk(frame_done == want_done, "R6", "frame_done", frame_done, want_done);
        if (want_done) begin
            chk(busy == 1'b0, "R6", "busy at frame end", busy, 0);
            done_seen = 1;
            want_done = 0;
        end
        case (mode)
            0: begin a = 1; v = 1; end
            1: begin a = ($urandom % 2) == 0; v = ($urandom % 2) == 0; end
            default: begin a = ($urandom % 3) == 0; v = ($urandom % 4) != 0; end
        endcase
        bus_ack   = a;
        pix_valid = v && (pidx < pixq.size());
        pix_data  = pix_valid ? 24'(pixq[pidx]) : 24'h0;
        #1;
        if (bus_valid && bus_ack) begin
            if (expq.size() == 0) begin
                chk(0, "R6", "unexpected bus word", {bus_a0, bus_word}, 0);
            end else begin
                exp = expq.pop_front();
                chk({15'h0, bus_a0, bus_word} == exp, cur_req, "bus word R10",
                    {bus_a0, bus_word}, exp);
                if (frame_on && expq.size() == 0) want_done = 1;
            end
        end
        if (pix_valid && pix_ready) pidx++;
    endtask

    task automatic run_frame(input int bs, input int ls, input int np, input int mode,
                             input bit with_cmd, input bit prm, input int cval,
                             input string req);
        int b, l;
        b = size_of(bs);
        l = width_of(ls);
        pixq.delete();
        expq.delete();
        for (int i = 0; i < np; i++) pixq.push_back(int'($urandom & 32'hFFFFFF));
        if (with_cmd) expq.push_back((int'(prm) << 16) | (cval & ((1 << l) - 1)));
        build(b, l, np);
        pidx = 0;
        want_done = 0;
        done_seen = 0;
        cur_req = req;
        @(negedge clk);
        cfg_bpp_sel   = 2'(bs);
        cfg_lines_sel = 2'(ls);
        cfg_pix_count = CNT_W'(np);
        start     = 1'b1;
        bus_ack   = 1'b0;
        pix_valid = 1'b0;
        if (with_cmd) begin
            cmd_valid    = 1'b1;
            cmd_is_param = prm;
            cmd_data     = 16'(cval);
            #1;
            chk(cmd_ready == 1'b1, "R12", "cmd_ready with start", cmd_ready, 1);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        // second start while busy with other settings: must be ignored (R7, R2)
        start         = 1'b1;
        cfg_pix_count = CNT_W'(np + 3);
        cfg_bpp_sel   = ~2'(bs);
        cfg_lines_sel = ~2'(ls);
        frame_on = 1;
        observe(mode);
        for (int k = 0; k < 3000 && !done_seen; k++) begin
            @(negedge clk);
            start = 1'b0;
            observe(mode);
        end
        frame_on = 0;
        chk(done_seen, "R6", "frame ended", done_seen, 1);
        chk(pidx == np, "R6", "pixels taken", pidx, np);
        chk(expq.size() == 0, "R6", "words left", expq.size(), 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            observe(0);
            chk(busy == 1'b0 && pix_ready == 1'b0, "R7", "idle after frame", busy, 0);
        end
    endtask

    task automatic send_cmd(input int ls, input bit prm, input int val);
        int          l;
        logic [16:0] expw;
        logic [16:0] first;
        l = width_of(ls);
        expw = {prm, 16'(val & ((1 << l) - 1))};
        @(negedge clk);
        cfg_lines_sel = 2'(ls);
        cmd_valid     = 1'b1;
        cmd_is_param  = prm;
        cmd_data      = 16'(val);
        bus_ack       = 1'b0;
        #1;
        chk(cmd_ready == 1'b1, "R8", "cmd_ready idle", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        first = {bus_a0, bus_word};
        chk(bus_valid == 1'b1, "R8", "command word valid", bus_valid, 1);
        chk(first == expw, "R8 R10", "command word", first, expw);
        @(negedge clk);
        chk(bus_valid == 1'b1 && {bus_a0, bus_word} == first, "R9", "word held without ack",
            {bus_a0, bus_word}, first);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        chk(bus_valid == 1'b0, "R9", "word gone after ack", bus_valid, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++;
            $display("FAIL R6 watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R11 reset state
        chk(busy == 1'b0, "R11", "busy", busy, 0);
        chk(bus_valid == 1'b0, "R11", "bus_valid", bus_valid, 0);
        chk(pix_ready == 1'b0, "R11", "pix_ready", pix_ready, 0);
        chk(cfg_err == 1'b0, "R11", "cfg_err", cfg_err, 0);
        chk(frame_done == 1'b0, "R11", "frame_done", frame_done, 0);
        chk(cmd_ready == 1'b1, "R11", "cmd_ready", cmd_ready, 1);

        // R8 single writes, command and parameter, two widths
        send_cmd(0, 1'b0, 16'hABCD);
        send_cmd(3, 1'b1, 16'h1234);
        send_cmd(1, 1'b1, 16'hFFFF);

        // R1 illegal pair: 16 bits on 9 lines
        @(negedge clk);
        cfg_bpp_sel = 2'd1; cfg_lines_sel = 2'd1; cfg_pix_count = CNT_W'(4); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R1", "illegal start busy", busy, 0);
        chk(cfg_err == 1'b1, "R1", "illegal start flag", cfg_err, 1);
        chk(pix_ready == 1'b0, "R1", "illegal start pix_ready", pix_ready, 0);
        chk(mode_of(16, 9) == 0, "R1", "model illegal pair", mode_of(16, 9), 0);

        // R3 one/two/three words per pixel
        run_frame(1, 0, 5, 0, 0, 0, 0, "R3");
        chk(cfg_err == 1'b0, "R1", "flag cleared by legal start", cfg_err, 0);
        run_frame(3, 0, 4, 1, 0, 0, 0, "R3");
        run_frame(1, 3, 6, 2, 0, 0, 0, "R3");
        run_frame(0, 2, 3, 1, 0, 0, 0, "R3");
        run_frame(2, 1, 4, 1, 0, 0, 0, "R3");
        run_frame(3, 2, 5, 2, 0, 0, 0, "R3");
        // R4 pair packing with even counts, R5 with odd counts
        run_frame(0, 0, 6, 0, 0, 0, 0, "R4");
        run_frame(2, 2, 4, 1, 0, 0, 0, "R4");
        run_frame(3, 3, 8, 2, 0, 0, 0, "R4");
        run_frame(0, 0, 5, 1, 0, 0, 0, "R5");
        run_frame(3, 3, 1, 0, 0, 0, 0, "R5");
        run_frame(2, 2, 7, 2, 0, 0, 0, "R5");

        // R7 zero count start
        @(negedge clk);
        cfg_bpp_sel = 2'd1; cfg_lines_sel = 2'd3; cfg_pix_count = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R7", "zero count busy", busy, 0);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(frame_done == 1'b0 && bus_valid == 1'b0, "R7", "zero count quiet",
                frame_done, 0);
        end

        // R12 command and start in the same cycle
        run_frame(3, 0, 3, 0, 1, 0, 16'h5A3C, "R12");
        run_frame(0, 0, 3, 1, 1, 1, 16'h00F7, "R12");

        finished = 1;
        report();
        $finish;
    end

endmodule